// File: doc/BRIEF.md
# Exception Entry Stack-Frame Sequencer

This block builds the frame that a processor leaves on the handler's stack when it enters an exception. A request gives the vector number, the current privilege level and a snapshot of the live registers: stack segment, stack pointer, flags, code segment, instruction pointer, a stack pointer for the handler's own stack, and an error code. The block looks up the handler gate through a small combinational query port. The gate table answers in the same cycle with a present bit, the gate width (32 or 16 bit) and the privilege level of the handler.

From those answers the block decides three things: whether a stack switch is needed, whether an error code belongs in the frame, and whether the request must be redirected because its gate is missing. A missing gate redirects to general protection. A missing general-protection gate escalates to double fault, and a missing double-fault gate ends the sequence with no frame. The block then emits one stack word per write request on a valid/ready handshake. When the frame is complete it pulses done for one cycle and reports the final stack pointer and the vector that was taken.

Top module: `exc_frame_seq`

## Requirements
- R1: An error-code word is added to the frame only when the vector finally taken is 0x08, 0x0A, 0x0B, 0x0C, 0x0D or 0x0E. Every other vector, reserved ones included, gets a frame without it.
- R2: When the gate's handler level differs from the current level, the frame starts at `new_sp` and its first two words are the old stack segment (zero-extended) and then the old stack pointer. Otherwise the frame starts at `cur_sp` and holds no saved stack words.
- R3: After any saved stack words, the words follow in this order: flags, code segment (zero-extended), the instruction pointer exactly as supplied (the faulting instruction's address), and finally the error code if there is one.
- R4: Through a 32-bit gate, each word is 32 bits wide, `wr_size32` is 1 and the stack steps by 4. Through a 16-bit gate, each word carries only the low 16 bits of its value (the upper bits are 0), `wr_size32` is 0 and the stack steps by 2.
- R5: The stack pointer is decremented by the step before every write. The first word goes to start minus step, and each later word goes one step below the previous one.
- R6: Only one write is outstanding at a time. While `wr_valid` is high and `wr_ready` is low, the address, data and size hold steady, and no new write is issued before the current one is accepted.
- R7: If the gate for a vector is not present, and that vector is not 0x0D and no escalation has yet taken place, the request restarts as vector 0x0D. Its error code is then (failed vector << 3) | 0x2: the index sits in bits 15:3, bit 2 (table indicator) is 0, bit 1 (interrupt table) is 1 and bit 0 (external) is 0.
- R8: If the gate for vector 0x0D is not present, the request escalates to vector 0x08 with an error code of 0.
- R9: If the double-fault gate is not present after an escalation, the block writes nothing. It pulses done with `done_sp` equal to `cur_sp` and `done_vector` equal to 0x08.
- R10: `done` is high for exactly one cycle at the end of each sequence. In that cycle, `done_sp` equals the address of the last word written and `done_vector` is the vector taken.
- R11: A request raised while a sequence is in progress is ignored and does not change the frame being built.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start an exception entry (accepted only when idle) |
| req_vector | input | 8 | Requested vector |
| req_err | input | 16 | Error code for vectors that carry one |
| cur_cpl | input | 2 | Current privilege level |
| cur_ss | input | 16 | Current stack segment |
| cur_sp | input | 32 | Current stack pointer |
| cur_flags | input | 32 | Current flags |
| cur_cs | input | 16 | Current code segment |
| cur_ip | input | 32 | Instruction pointer to save |
| new_sp | input | 32 | Handler stack top, used on a privilege change |
| gate_vec | output | 8 | Vector whose gate is being queried |
| gate_present | input | 1 | Queried gate is present |
| gate_is32 | input | 1 | Queried gate is 32-bit |
| gate_dpl | input | 2 | Handler privilege level of the queried gate |
| wr_valid | output | 1 | Stack write request |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | 32 | Write address |
| wr_data | output | 32 | Write data |
| wr_size32 | output | 1 | 1 = 32-bit word, 0 = 16-bit word |
| done | output | 1 | One-cycle end-of-sequence pulse |
| done_sp | output | 32 | Final stack pointer |
| done_vector | output | 8 | Vector taken |

## Verification
The bench covers the three-step redirect chain: a missing ordinary gate, a missing general-protection gate, and a missing double-fault gate. A design that loops, skips the escalation or keeps the wrong error code shows up as an extra write, a missing write or a wrong word. Reserved vectors and vectors 0x08/0x0A sit next to the error-code set, so a design with an off-by-one range check adds or drops the last word. Stack switches through 16-bit gates catch a design that steps by 4 or leaves the upper bits in place. A request poked in mid-frame catches a design that re-latches its inputs while busy, because the frame then contains the wrong vector or wrong values.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

    localparam int ADDR_W = 32;
    localparam int SEG_W  = 16;
    localparam int VEC_W  = 8;
    localparam int NSLOT  = 6;

    localparam logic [VEC_W-1:0] VEC_GP = 8'h0D;
    localparam logic [VEC_W-1:0] VEC_DF = 8'h08;

    typedef enum logic [2:0] {
        SL_OLD_SS = 3'd0,
        SL_OLD_SP = 3'd1,
        SL_FLAGS  = 3'd2,
        SL_CS     = 3'd3,
        SL_IP     = 3'd4,
        SL_ERR    = 3'd5
    } slot_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RESOLVE,
        ST_PUSH,
        ST_DONE
    } state_e;

    typedef enum logic [1:0] {
        ACT_TAKE,
        ACT_TO_GP,
        ACT_TO_DF,
        ACT_ABORT
    } action_e;

    typedef struct packed {
        logic [1:0]        cpl;
        logic [SEG_W-1:0]  ss;
        logic [ADDR_W-1:0] sp;
        logic [ADDR_W-1:0] flags;
        logic [SEG_W-1:0]  cs;
        logic [ADDR_W-1:0] ip;
        logic [ADDR_W-1:0] new_sp;
    } frame_ctx_t;

    typedef struct packed {
        logic  valid;
        slot_e idx;
    } slot_pick_t;

    function automatic logic carries_err(input logic [VEC_W-1:0] v);
        return (v == 8'h08) || (v >= 8'h0A && v <= 8'h0E);
    endfunction

    function automatic slot_pick_t pick_after(input logic [NSLOT-1:0] mask,
                                              input int unsigned       from,
                                              input logic              inclusive);
        slot_pick_t p;
        p.valid = 1'b0;
        p.idx   = SL_OLD_SS;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (mask[i] && ((i > int'(from)) || (inclusive && i == int'(from)))) begin
                p.valid = 1'b1;
                p.idx   = slot_e'(i[2:0]);
            end
        end
        return p;
    endfunction

endpackage

// File: rtl/exc_gate_resolve.sv
module exc_gate_resolve
    import exc_seq_pkg::*;
(
    input  logic [VEC_W-1:0] vec,
    input  logic             escalated,
    input  logic             present,
    output action_e          action,
    output logic [SEG_W-1:0] redirect_err
);
    always_comb begin
        if (present)
            action = ACT_TAKE;
        else if (escalated)
            action = ACT_ABORT;
        else if (vec == VEC_GP)
            action = ACT_TO_DF;
        else
            action = ACT_TO_GP;
    end

    // selector index = failed vector, interrupt-table bit set, local/external clear
    assign redirect_err = {{(SEG_W-VEC_W-3){1'b0}}, vec, 3'b010};
endmodule

// File: rtl/exc_frame_word.sv
module exc_frame_word
    import exc_seq_pkg::*;
(
    input  slot_e             slot,
    input  frame_ctx_t        ctx,
    input  logic [SEG_W-1:0]  err,
    input  logic              is32,
    output logic [ADDR_W-1:0] data
);
    logic [ADDR_W-1:0] raw;

    always_comb begin
        unique case (slot)
            SL_OLD_SS: raw = {{(ADDR_W-SEG_W){1'b0}}, ctx.ss};
            SL_OLD_SP: raw = ctx.sp;
            SL_FLAGS:  raw = ctx.flags;
            SL_CS:     raw = {{(ADDR_W-SEG_W){1'b0}}, ctx.cs};
            SL_IP:     raw = ctx.ip;
            default:   raw = {{(ADDR_W-SEG_W){1'b0}}, err};
        endcase
    end

    assign data = is32 ? raw : {{(ADDR_W-16){1'b0}}, raw[15:0]};
endmodule

// File: rtl/exc_frame_seq.sv
module exc_frame_seq
    import exc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [VEC_W-1:0]  req_vector,
    input  logic [SEG_W-1:0]  req_err,
    input  logic [1:0]        cur_cpl,
    input  logic [SEG_W-1:0]  cur_ss,
    input  logic [ADDR_W-1:0] cur_sp,
    input  logic [ADDR_W-1:0] cur_flags,
    input  logic [SEG_W-1:0]  cur_cs,
    input  logic [ADDR_W-1:0] cur_ip,
    input  logic [ADDR_W-1:0] new_sp,
    output logic [VEC_W-1:0]  gate_vec,
    input  logic              gate_present,
    input  logic              gate_is32,
    input  logic [1:0]        gate_dpl,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] wr_data,
    output logic              wr_size32,
    output logic              done,
    output logic [ADDR_W-1:0] done_sp,
    output logic [VEC_W-1:0]  done_vector
);
    state_e            state_q;
    frame_ctx_t        ctx_q;
    logic [VEC_W-1:0]  vec_q;
    logic [SEG_W-1:0]  err_q;
    logic              esc_q;
    logic              is32_q;
    logic [NSLOT-1:0]  mask_q;
    slot_e             slot_q;
    logic [ADDR_W-1:0] sp_q;

    action_e           action;
    logic [SEG_W-1:0]  redirect_err;
    logic [ADDR_W-1:0] word;
    logic [ADDR_W-1:0] step_q;
    logic [ADDR_W-1:0] take_step;
    logic              take_switch;
    logic [NSLOT-1:0]  take_mask;
    slot_pick_t        first_pick;
    slot_pick_t        next_pick;

    exc_gate_resolve u_resolve (
        .vec          (vec_q),
        .escalated    (esc_q),
        .present      (gate_present),
        .action       (action),
        .redirect_err (redirect_err)
    );

    exc_frame_word u_word (
        .slot (slot_q),
        .ctx  (ctx_q),
        .err  (err_q),
        .is32 (is32_q),
        .data (word)
    );

    assign take_switch = (gate_dpl != ctx_q.cpl);
    assign take_step   = gate_is32 ? ADDR_W'(4) : ADDR_W'(2);
    assign step_q      = is32_q ? ADDR_W'(4) : ADDR_W'(2);

    always_comb begin
        take_mask            = '0;
        take_mask[SL_OLD_SS] = take_switch;
        take_mask[SL_OLD_SP] = take_switch;
        take_mask[SL_FLAGS]  = 1'b1;
        take_mask[SL_CS]     = 1'b1;
        take_mask[SL_IP]     = 1'b1;
        take_mask[SL_ERR]    = carries_err(vec_q);
    end

    assign first_pick = pick_after(take_mask, 0, 1'b1);
    assign next_pick  = pick_after(mask_q, int'(slot_q), 1'b0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ctx_q   <= '0;
            vec_q   <= '0;
            err_q   <= '0;
            esc_q   <= 1'b0;
            is32_q  <= 1'b0;
            mask_q  <= '0;
            slot_q  <= SL_OLD_SS;
            sp_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        ctx_q.cpl    <= cur_cpl;
                        ctx_q.ss     <= cur_ss;
                        ctx_q.sp     <= cur_sp;
                        ctx_q.flags  <= cur_flags;
                        ctx_q.cs     <= cur_cs;
                        ctx_q.ip     <= cur_ip;
                        ctx_q.new_sp <= new_sp;
                        vec_q        <= req_vector;
                        err_q        <= req_err;
                        esc_q        <= 1'b0;
                        state_q      <= ST_RESOLVE;
                    end
                end
                ST_RESOLVE: begin
                    unique case (action)
                        ACT_TAKE: begin
                            is32_q  <= gate_is32;
                            mask_q  <= take_mask;
                            slot_q  <= first_pick.idx;
                            sp_q    <= (take_switch ? ctx_q.new_sp : ctx_q.sp) - take_step;
                            state_q <= ST_PUSH;
                        end
                        ACT_TO_GP: begin
                            vec_q <= VEC_GP;
                            err_q <= redirect_err;
                        end
                        ACT_TO_DF: begin
                            vec_q <= VEC_DF;
                            err_q <= '0;
                            esc_q <= 1'b1;
                        end
                        default: begin
                            sp_q    <= ctx_q.sp;
                            state_q <= ST_DONE;
                        end
                    endcase
                end
                ST_PUSH: begin
                    if (wr_ready) begin
                        if (next_pick.valid) begin
                            slot_q <= next_pick.idx;
                            sp_q   <= sp_q - step_q;
                        end else begin
                            state_q <= ST_DONE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign gate_vec    = vec_q;
    assign wr_valid    = (state_q == ST_PUSH);
    assign wr_addr     = sp_q;
    assign wr_data     = word;
    assign wr_size32   = is32_q;
    assign done        = (state_q == ST_DONE);
    assign done_sp     = sp_q;
    assign done_vector = vec_q;

    // R6: a pending write holds its content until accepted
    a_r6_hold_until_ready: assert property (@(posedge clk) disable iff (rst)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_size32));

    // R5: each following write sits one step below the previous one
    a_r5_step_down: assert property (@(posedge clk) disable iff (rst)
        wr_valid && wr_ready |=> !wr_valid ||
            (wr_addr == $past(wr_addr) - (wr_size32 ? ADDR_W'(4) : ADDR_W'(2))));

    // R10: done is a single-cycle pulse and never overlaps a write
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r10_done_no_write: assert property (@(posedge clk) disable iff (rst)
        done |-> !wr_valid);

    // R11: captured context stays frozen while a sequence runs
    a_r11_ctx_frozen: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |=> $stable(ctx_q));

    // R1: the error word only appears for a vector of the error-code set
    a_r1_err_slot: assert property (@(posedge clk) disable iff (rst)
        wr_valid && (slot_q == SL_ERR) |-> carries_err(done_vector));

    // R4: a 16-bit frame never carries upper data bits
    a_r4_narrow_data: assert property (@(posedge clk) disable iff (rst)
        wr_valid && !wr_size32 |-> (wr_data[ADDR_W-1:16] == '0));
endmodule

// File: tb/test_exc_frame_seq.sv
module test_exc_frame_seq;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [7:0]  req_vector;
    logic [15:0] req_err;
    logic [1:0]  cur_cpl;
    logic [15:0] cur_ss;
    logic [31:0] cur_sp;
    logic [31:0] cur_flags;
    logic [15:0] cur_cs;
    logic [31:0] cur_ip;
    logic [31:0] new_sp;
    logic [7:0]  gate_vec;
    logic        gate_present;
    logic        gate_is32;
    logic [1:0]  gate_dpl;
    logic        wr_valid;
    logic        wr_ready;
    logic [31:0] wr_addr;
    logic [31:0] wr_data;
    logic        wr_size32;
    logic        done;
    logic [31:0] done_sp;
    logic [7:0]  done_vector;

    logic [2:0]  pres;   // bit0 ordinary gates, bit1 vector 0x0D, bit2 vector 0x08
    logic        g32;
    logic [1:0]  gdpl;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    exc_frame_seq i_exc_frame_seq (.*);

    always_comb begin
        if (gate_vec == 8'h0D)      gate_present = pres[1];
        else if (gate_vec == 8'h08) gate_present = pres[2];
        else                        gate_present = pres[0];
        gate_is32 = g32;
        gate_dpl  = gdpl;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // {vector[7:0], cpl[1:0], dpl[1:0], is32, pres[2:0]}
    localparam int NCASE = 15;
    localparam logic [15:0] TBL [NCASE] = '{
        {8'h0E, 2'd3, 2'd0, 1'b1, 3'b111},
        {8'h03, 2'd0, 2'd0, 1'b1, 3'b111},
        {8'h0D, 2'd3, 2'd0, 1'b0, 3'b111},
        {8'h06, 2'd0, 2'd0, 1'b0, 3'b111},
        {8'h08, 2'd0, 2'd0, 1'b1, 3'b111},
        {8'h0A, 2'd1, 2'd1, 1'b1, 3'b111},
        {8'h0B, 2'd2, 2'd0, 1'b0, 3'b111},
        {8'h0C, 2'd0, 2'd0, 1'b1, 3'b111},
        {8'h09, 2'd0, 2'd0, 1'b1, 3'b111},
        {8'h0F, 2'd0, 2'd0, 1'b1, 3'b111},
        {8'h00, 2'd3, 2'd0, 1'b1, 3'b110},
        {8'h21, 2'd0, 2'd0, 1'b1, 3'b110},
        {8'h05, 2'd0, 2'd0, 1'b1, 3'b100},
        {8'h06, 2'd0, 2'd0, 1'b1, 3'b000},
        {8'h0D, 2'd0, 2'd0, 1'b0, 3'b101}
    };

    task automatic run_case(input logic [15:0] e, input int seed, input bit poke);
        logic [7:0]  v;
        logic [15:0] err;
        bit          abort;
        bit          esc;
        bit          sw;
        bit          is32;
        logic [31:0] step;
        logic [31:0] sp;
        logic [31:0] vals [6];
        bit          en [6];
        logic [31:0] ea [6];
        logic [31:0] ed [6];
        int          n;
        int          got;
        int          stall;
        bit          finished;
        bit          poked;

        v    = e[15:8];
        pres = e[2:0];
        g32  = e[3];
        gdpl = e[5:4];
        cur_cpl   = e[7:6];
        cur_ss    = 16'h0010 + 16'(seed);
        cur_sp    = 32'h0000_8000 + 32'(seed * 16);
        cur_flags = 32'hA5C3_0246 ^ 32'(seed);
        cur_cs    = 16'h001B + 16'(seed);
        cur_ip    = 32'h1234_5678 + 32'(seed);
        new_sp    = 32'h0002_0000 - 32'(seed * 32);
        req_err   = 16'hBEE0 + 16'(seed);

        // expected vector and error code (R7, R8, R9)
        err = req_err; abort = 0; esc = 0;
        for (int k = 0; k < 4; k++) begin
            bit p;
            p = (v == 8'h0D) ? pres[1] : (v == 8'h08) ? pres[2] : pres[0];
            if (p || abort) break;
            if (esc) abort = 1;
            else if (v == 8'h0D) begin v = 8'h08; err = 16'h0; esc = 1; end
            else begin err = {5'b0, v, 3'b010}; v = 8'h0D; end
        end

        // expected frame (R1..R5)
        is32 = g32;
        step = is32 ? 32'd4 : 32'd2;
        sw   = (gdpl != cur_cpl);
        vals = '{{16'h0, cur_ss}, cur_sp, cur_flags, {16'h0, cur_cs}, cur_ip, {16'h0, err}};
        en   = '{sw, sw, 1'b1, 1'b1, 1'b1,
                 (v == 8'h08) || (v >= 8'h0A && v <= 8'h0E)};
        sp   = sw ? new_sp : cur_sp;
        n    = 0;
        if (!abort) begin
            for (int s = 0; s < 6; s++) begin
                if (en[s]) begin
                    sp    = sp - step;
                    ea[n] = sp;
                    ed[n] = is32 ? vals[s] : {16'h0, vals[s][15:0]};
                    n++;
                end
            end
        end else begin
            sp = cur_sp;
        end

        @(negedge clk);
        req_valid  = 1'b1;
        req_vector = e[15:8];
        @(negedge clk);
        req_valid = 1'b0;

        got = 0; stall = 1; finished = 0; poked = 0;
        for (int c = 0; c < 200 && !finished; c++) begin
            @(negedge clk);
            wr_ready  = 1'b0;
            req_valid = 1'b0;
            if (done) begin
                finished = 1;
                chk(got == n, "R2", "write count", 32'(got), 32'(n));
                chk(done_vector == v, "R10", "done_vector", {24'h0, done_vector}, {24'h0, v});
                chk(done_sp == sp, abort ? "R9" : "R10", "done_sp", done_sp, sp);
                @(negedge clk);
                chk(!done, "R10", "done pulse width", {31'h0, done}, 32'h0);
            end else if (wr_valid) begin
                if (poke && !poked) begin
                    req_valid  = 1'b1;
                    req_vector = 8'h03;
                    poked = 1;
                end
                if (stall > 0) begin
                    stall--;
                end else begin
                    if (got < n) begin
                        chk(wr_addr == ea[got], "R5", "wr_addr", wr_addr, ea[got]);
                        chk(wr_data == ed[got], got == n - 1 ? "R1" : "R3", "wr_data", wr_data, ed[got]);
                        chk(wr_size32 == is32, "R4", "wr_size32", {31'h0, wr_size32}, {31'h0, is32});
                    end else begin
                        chk(1'b0, "R1", "extra write", wr_addr, 32'h0);
                    end
                    got++;
                    wr_ready = 1'b1;
                    stall = (seed + got) % 3;
                end
            end
        end
        if (!finished) chk(1'b0, "R10", "no done", 32'(got), 32'(n));
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_vector = '0; req_err = '0;
        cur_cpl = '0; cur_ss = '0; cur_sp = '0; cur_flags = '0; cur_cs = '0;
        cur_ip = '0; new_sp = '0; wr_ready = 1'b0; pres = 3'b111; g32 = 1'b1; gdpl = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!wr_valid, "R6", "reset wr_valid", {31'h0, wr_valid}, 32'h0);
        chk(!done, "R10", "reset done", {31'h0, done}, 32'h0);

        for (int i = 0; i < NCASE; i++) run_case(TBL[i], i, 1'b0);

        // R11: mid-frame request with another vector must not disturb the frame
        run_case({8'h0E, 2'd3, 2'd0, 1'b0, 3'b111}, 7, 1'b1);
        run_case({8'h21, 2'd0, 2'd0, 1'b1, 3'b110}, 11, 1'b1);

        // R6: idle block with no request issues nothing
        repeat (5) @(negedge clk);
        chk(!wr_valid && !done, "R6", "idle quiet", {30'h0, wr_valid, done}, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL R10 watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule